// File: doc/BRIEF.md
# Multi-Cycle Processor Main Controller

This block is the sequencing controller of a small multi-cycle processor. That processor shares one memory between instruction and data accesses, owns a single ALU, and keeps intermediate results in holding registers (instruction, memory data, two operands, ALU result). The controller is a Moore machine. It reads only the 6-bit opcode field of the held instruction. In each state it drives the strobes and multiplexer selects that the datapath needs for that step.

Every instruction starts with a shared fetch step and a shared decode step. Control then branches by opcode. Loads take five cycles, stores and register-register operations take four, and conditional branches and jumps take three. An unknown opcode returns to fetch straight after decode and writes nothing. The current state code is a port so that the surrounding datapath and its tests can observe the sequence.

Top module: `mc_main_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in fetch (state code 0). Reset overrides any state, including the middle of an instruction.
- R2: Fetch (code 0) drives pcWrite=1, memRd=1, instrLoad=1, addrFromAlu=0, opASel=0, opBSel=01, aluMode=00 and pcSel=00, and always moves to decode (code 1).
- R3: Decode (code 1) drives opASel=0, opBSel=11 and aluMode=00. It moves to code 2 for opcodes 100011 and 101011, to code 6 for 000000, to code 8 for 000100, to code 9 for 000010, and to code 0 for every other opcode.
- R4: Address state (code 2) drives opASel=1, opBSel=10 and aluMode=00. It moves to code 3 for opcode 100011 and to code 5 for opcode 101011.
- R5: Load-read state (code 3) drives memRd=1 and addrFromAlu=1, and moves to code 4.
- R6: Load-writeback state (code 4) drives regWr=1, wbFromMem=1 and dstFromRd=0, and moves to code 0.
- R7: Store state (code 5) drives memWr=1 and addrFromAlu=1, and moves to code 0. memRd and memWr are never high together.
- R8: Execute state (code 6) drives opASel=1, opBSel=00 and aluMode=10, and moves to code 7.
- R9: Register-completion state (code 7) drives dstFromRd=1, regWr=1 and wbFromMem=0, and moves to code 0.
- R10: Branch state (code 8) drives opASel=1, opBSel=00, aluMode=01, pcWriteIfZero=1 and pcSel=01, and moves to code 0.
- R11: Jump state (code 9) drives pcWrite=1 and pcSel=10, and moves to code 0. pcWrite is never high while pcSel=01.
- R12: In every state, each strobe not listed for that state is 0. From fetch back to fetch, opcode 100011 takes 5 cycles, 101011 and 000000 take 4, 000100 and 000010 take 3, and any other opcode takes 2.
- R13: The opcode is ignored in every state except decode and address. Changing it in any other state does not alter the state sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| pcWrite | output | 1 | Unconditional program-counter load |
| pcWriteIfZero | output | 1 | Program-counter load when the ALU result is zero |
| addrFromAlu | output | 1 | Memory address taken from the ALU result register instead of the PC |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| instrLoad | output | 1 | Instruction register load |
| wbFromMem | output | 1 | Register write data taken from the memory data register |
| dstFromRd | output | 1 | Destination register from bits 15:11 instead of 20:16 |
| regWr | output | 1 | Register file write strobe |
| opASel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| opBSel | output | 2 | ALU operand B: 00 = register B, 01 = constant 4, 10 = extended offset, 11 = extended offset shifted by 2 |
| aluMode | output | 2 | 00 = add, 01 = subtract, 10 = decode from function field |
| pcSel | output | 2 | Next PC: 00 = ALU, 01 = ALU result register, 10 = jump target |
| stateCode | output | 4 | Current state code |

## Verification
A wrong state shows at the ports in the same cycle it is entered, because every state has its own strobe pattern. A bad transition taken at decode shows one cycle later as the wrong state code and the wrong strobes. A stray return to fetch shows as an instruction that is too short, and a missed return shows as one that is too long. All 64 opcodes are therefore walked from fetch back to fetch. On every cycle the state code and all strobes are compared against values derived from the opcode class alone. Junk opcodes are driven in every state where the opcode must be ignored, so any state that wrongly reads the opcode changes the observed sequence.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OP_W    = 6;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LOADRD  = 4'd3,
    ST_LOADWB  = 4'd4,
    ST_STORE   = 4'd5,
    ST_EXEC    = 4'd6,
    ST_RDONE   = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } ctrlState_t;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  // ALU operand B selects
  localparam logic [1:0] B_REG   = 2'b00;
  localparam logic [1:0] B_FOUR  = 2'b01;
  localparam logic [1:0] B_IMM   = 2'b10;
  localparam logic [1:0] B_IMMSH = 2'b11;

  // ALU modes
  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  // next-PC selects
  localparam logic [1:0] PC_ALU  = 2'b00;
  localparam logic [1:0] PC_HELD = 2'b01;
  localparam logic [1:0] PC_JMP  = 2'b10;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteIfZero;
    logic       addrFromAlu;
    logic       memRd;
    logic       memWr;
    logic       instrLoad;
    logic       wbFromMem;
    logic       dstFromRd;
    logic       regWr;
    logic       opASel;
    logic [1:0] opBSel;
    logic [1:0] aluMode;
    logic [1:0] pcSel;
  } strobes_t;

endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output ctrlState_t      state
);

  ctrlState_t nextState;

  always_comb begin
    nextState = ST_FETCH;
    case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: nextState = ST_ADDR;
          OP_RTYPE:          nextState = ST_EXEC;
          OP_BEQ:            nextState = ST_BRANCH;
          OP_JUMP:           nextState = ST_JUMP;
          default:           nextState = ST_FETCH;
        endcase
      end
      ST_ADDR:   nextState = (opcode == OP_LOAD) ? ST_LOADRD : ST_STORE;
      ST_LOADRD: nextState = ST_LOADWB;
      ST_EXEC:   nextState = ST_RDONE;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  // R1: first cycle out of reset is fetch
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state == ST_FETCH);

  // R2: fetch always goes to decode
  p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_DECODE);

  // R5: load read is followed by write-back
  p_load_chain_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOADRD |=> state == ST_LOADWB);

  // R8: execute is followed by register completion
  p_exec_done_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_EXEC |=> state == ST_RDONE);

  // R12: completion states return to fetch
  p_done_fetch_r12: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_LOADWB, ST_STORE, ST_RDONE, ST_BRANCH, ST_JUMP})
      |=> state == ST_FETCH);

endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  ctrlState_t state,
  output strobes_t   strobes
);

  always_comb begin
    strobes = '0;
    case (state)
      ST_FETCH: begin
        strobes.memRd     = 1'b1;
        strobes.instrLoad = 1'b1;
        strobes.opBSel    = B_FOUR;
        strobes.aluMode   = ALU_ADD;
        strobes.pcSel     = PC_ALU;
        strobes.pcWrite   = 1'b1;
      end
      ST_DECODE: begin
        strobes.opBSel  = B_IMMSH;
        strobes.aluMode = ALU_ADD;
      end
      ST_ADDR: begin
        strobes.opASel  = 1'b1;
        strobes.opBSel  = B_IMM;
        strobes.aluMode = ALU_ADD;
      end
      ST_LOADRD: begin
        strobes.memRd       = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      ST_LOADWB: begin
        strobes.regWr     = 1'b1;
        strobes.wbFromMem = 1'b1;
      end
      ST_STORE: begin
        strobes.memWr       = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      ST_EXEC: begin
        strobes.opASel  = 1'b1;
        strobes.opBSel  = B_REG;
        strobes.aluMode = ALU_FUNC;
      end
      ST_RDONE: begin
        strobes.dstFromRd = 1'b1;
        strobes.regWr     = 1'b1;
      end
      ST_BRANCH: begin
        strobes.opASel        = 1'b1;
        strobes.opBSel        = B_REG;
        strobes.aluMode       = ALU_SUB;
        strobes.pcWriteIfZero = 1'b1;
        strobes.pcSel         = PC_HELD;
      end
      ST_JUMP: begin
        strobes.pcWrite = 1'b1;
        strobes.pcSel   = PC_JMP;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mc_main_ctrl.sv
module mc_main_ctrl
  import mcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  output logic               pcWrite,
  output logic               pcWriteIfZero,
  output logic               addrFromAlu,
  output logic               memRd,
  output logic               memWr,
  output logic               instrLoad,
  output logic               wbFromMem,
  output logic               dstFromRd,
  output logic               regWr,
  output logic               opASel,
  output logic [1:0]         opBSel,
  output logic [1:0]         aluMode,
  output logic [1:0]         pcSel,
  output logic [STATE_W-1:0] stateCode
);

  ctrlState_t state;
  strobes_t   strobes;

  mcc_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .state  (state)
  );

  mcc_decode u_dec (
    .state   (state),
    .strobes (strobes)
  );

  assign pcWrite       = strobes.pcWrite;
  assign pcWriteIfZero = strobes.pcWriteIfZero;
  assign addrFromAlu   = strobes.addrFromAlu;
  assign memRd         = strobes.memRd;
  assign memWr         = strobes.memWr;
  assign instrLoad     = strobes.instrLoad;
  assign wbFromMem     = strobes.wbFromMem;
  assign dstFromRd     = strobes.dstFromRd;
  assign regWr         = strobes.regWr;
  assign opASel        = strobes.opASel;
  assign opBSel        = strobes.opBSel;
  assign aluMode       = strobes.aluMode;
  assign pcSel         = strobes.pcSel;
  assign stateCode     = state;

  // R7: never read and write memory together
  p_mem_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRd, memWr}));

  // R11: an unconditional PC load never takes the held-result source
  p_pc_source_r11: assert property (@(posedge clk) disable iff (rst)
    pcWrite |-> pcSel != PC_HELD);

  // R6: memory write-back only right after a memory read
  p_wb_after_read_r6: assert property (@(posedge clk) disable iff (rst)
    wbFromMem |-> $past(memRd) && $past(addrFromAlu));

endmodule

// File: tb/sim_mc_main_ctrl.sv
module sim_mc_main_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pcWrite, pcWriteIfZero, addrFromAlu, memRd, memWr, instrLoad;
  logic       wbFromMem, dstFromRd, regWr, opASel;
  logic [1:0] opBSel, aluMode, pcSel;
  logic [3:0] stateCode;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2 clk = ~clk; // 250 MHz

  mc_main_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pcWrite(pcWrite), .pcWriteIfZero(pcWriteIfZero), .addrFromAlu(addrFromAlu),
    .memRd(memRd), .memWr(memWr), .instrLoad(instrLoad), .wbFromMem(wbFromMem),
    .dstFromRd(dstFromRd), .regWr(regWr), .opASel(opASel), .opBSel(opBSel),
    .aluMode(aluMode), .pcSel(pcSel), .stateCode(stateCode)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R12 watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // packed {pcWrite,pcWriteIfZero,addrFromAlu,memRd,memWr,instrLoad,
  //         wbFromMem,dstFromRd,regWr,opASel,opBSel,aluMode,pcSel}
  function automatic logic [15:0] expOut(input logic [3:0] s);
    logic [15:0] v = 16'd0;
    case (s)
      4'd0: begin v[15] = 1; v[12] = 1; v[10] = 1; v[5:4] = 2'b01; end   // R2
      4'd1: begin v[5:4] = 2'b11; end                                   // R3
      4'd2: begin v[6] = 1; v[5:4] = 2'b10; end                         // R4
      4'd3: begin v[12] = 1; v[13] = 1; end                             // R5
      4'd4: begin v[7] = 1; v[9] = 1; end                               // R6
      4'd5: begin v[11] = 1; v[13] = 1; end                             // R7
      4'd6: begin v[6] = 1; v[3:2] = 2'b10; end                         // R8
      4'd7: begin v[8] = 1; v[7] = 1; end                               // R9
      4'd8: begin v[6] = 1; v[3:2] = 2'b01; v[14] = 1; v[1:0] = 2'b01; end // R10
      4'd9: begin v[15] = 1; v[1:0] = 2'b10; end                        // R11
      default: v = 16'd0;
    endcase
    return v;
  endfunction

  function automatic string reqOf(input logic [3:0] s);
    case (s)
      4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
      4'd3: return "R5";  4'd4: return "R6";  4'd5: return "R7";
      4'd6: return "R8";  4'd7: return "R9";  4'd8: return "R10";
      4'd9: return "R11"; default: return "R12";
    endcase
  endfunction

  function automatic logic [3:0] expNext(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: begin
        if (op == 6'b100011 || op == 6'b101011) return 4'd2;
        if (op == 6'b000000) return 4'd6;
        if (op == 6'b000100) return 4'd8;
        if (op == 6'b000010) return 4'd9;
        return 4'd0;
      end
      4'd2: return (op == 6'b100011) ? 4'd3 : 4'd5;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int expLen(input logic [5:0] op);
    if (op == 6'b100011) return 5;
    if (op == 6'b101011 || op == 6'b000000) return 4;
    if (op == 6'b000100 || op == 6'b000010) return 3;
    return 2;
  endfunction

  task automatic checkState(input logic [3:0] e, input string req);
    logic [15:0] act;
    act = {pcWrite, pcWriteIfZero, addrFromAlu, memRd, memWr, instrLoad,
           wbFromMem, dstFromRd, regWr, opASel, opBSel, aluMode, pcSel};
    vectors++;
    if (stateCode !== e) begin
      fails++;
      $display("FAIL %s state: actual %0d expected %0d", req, stateCode, e);
    end
    vectors++;
    if (act !== expOut(e)) begin
      fails++;
      $display("FAIL %s strobes in state %0d (R12 others zero): actual %b expected %b",
               req, e, act, expOut(e));
    end
  endtask

  // walk one instruction from fetch back to fetch; junk opcode outside
  // decode/address states exercises R13
  task automatic runInstr(input logic [5:0] op);
    logic [3:0] e = 4'd0;
    int n = 0;
    do begin
      checkState(e, reqOf(e));
      if (e == 4'd1 || e == 4'd2) opcode = op;
      else                        opcode = op ^ (6'h15 + 6'(n)); // R13 junk
      e = expNext(e, op);
      n++;
      @(negedge clk);
    end while (e != 4'd0);
    vectors++;
    if (n != expLen(op)) begin
      fails++;
      $display("FAIL R12 length for opcode %b: actual %0d expected %0d", op, n, expLen(op));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkState(4'd0, "R1");               // held in reset
    rst = 1'b0;
    checkState(4'd0, "R1");
    for (int i = 0; i < 64; i++) runInstr(6'(i));
    // named classes again, in a different order, with R13 junk
    runInstr(6'b000010);
    runInstr(6'b100011);
    runInstr(6'b000100);
    runInstr(6'b101011);
    runInstr(6'b000000);
    runInstr(6'b111111);
    // R1: reset in the middle of a load
    opcode = 6'b100011;
    @(negedge clk);                        // decode
    @(negedge clk);                        // address
    checkState(4'd2, "R4");
    rst = 1'b1;
    @(negedge clk);
    checkState(4'd0, "R1");
    @(negedge clk);
    checkState(4'd0, "R1");
    rst = 1'b0;
    runInstr(6'b100011);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule